// File: doc/BRIEF.md
# Memory Self-Test Controller with Failure Logging

This block sequences a memory self-test under register control. Software sets a clock-activate bit and picks which test algorithms and which RAM groups take part. It also sets a type-matching mode and a microcode-source field, then issues a go command. For every selected pair of algorithm and group, the engine writes a pattern into every word of that group of a built-in SRAM model. It then reads each word back and compares it with the pattern.

On a miscompare the engine halts where it is and logs diagnostics. The log holds a sticky fail flag, the algorithm and group where the first error occurred, a saturating error count, and the first failing word address and read data. Software inspects these and writes a resume command. The engine then continues from the next address. A done flag marks the end of the run, and a clear fail flag at that point means the memory passed.

The SRAM model has a fault hook. It inverts one chosen data bit whenever one chosen word is read, so that failures can be provoked from the ports. Four fixed patterns stand in for the microcoded algorithms.

Top module: `mbist_ctrl`

## Requirements
- R1: Register addresses are ACT=0, ALG=1, GLO=2, GHI=3, OVR=4, SRC=5, GO=6, CMD=7, STAT=8, LOC=9, CNT=10, FADR=11 and FDAT=12. Reads are returned one cycle after the read address. After reset, ALG reads 0x0F (all algorithms selected), OVR reads 1, ACT, SRC, GLO and GHI read 0, and STAT reads 0. STAT holds done in bit 0, fail in bit 1 and paused in bit 2.
- R2: A run starts only when 0x14 is written to GO while ACT bit 0 is 1 and SRC reads 3. Any other value, ACT=0 or a different SRC leaves the engine idle, and done stays 0.
- R3: Pairs are visited with the algorithm as the outer loop and the group as the inner loop. Algorithm a runs on group g only if ALG bit a is set and the group mask bit is set, where GLO bits 0..3 cover groups 0..3 and GHI bits 0..3 cover groups 4..7. With OVR=1, the low bit of g must also equal the low bit of a. With OVR=0, that type match is ignored.
- R4: Each word at address d is written with a pattern chosen by the algorithm and then compared on read. Algorithm 0 writes 0xFF, algorithm 1 writes 0xAA, algorithm 2 writes {d,d} and algorithm 3 writes ~{d,d}. An enabled fault inverts bit flt_bit of every read of word flt_addr in group flt_grp.
- R5: A miscompare pauses the engine and sets the fail flag (STAT bit 1), and STAT bit 2 reads 1 while paused. The first failure records LOC = algorithm*8 + group, FADR = the word address and FDAT = the data actually read.
- R6: FADR, FDAT and LOC are captured only when the count goes from 0 to 1. Later failures leave them unchanged.
- R7: The fail count (CNT, 2 bits) increments on every miscompare and holds at 3 instead of wrapping.
- R8: Writing 2 to CMD while paused resumes at the next address. Any other CMD value leaves the engine paused.
- R9: After the last selected pair, done (STAT bit 0) is set and the fail flag shows whether any miscompare occurred. A new start clears done, fail, count and capture.
- R10: While ACT is 0 the engine does not advance, and it continues from the same point when ACT returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 8 | Registered read data |
| flt_en | input | 1 | Enable the injected read fault |
| flt_grp | input | 3 | Group of the faulty word |
| flt_addr | input | 4 | Address of the faulty word |
| flt_bit | input | 3 | Data bit inverted on read |

## Verification
The hardest state to reach from the ports is a run with more miscompares than the counter can hold. Getting there also requires several resume commands in a row, each issued at a moment the bench cannot predict. The bench provokes this by placing an inverting fault on one word and turning off the type match (OVR=0), so that every selected algorithm hits the same faulty word. It then polls STAT and resumes on each pause, counting the pauses against a model of the pair ordering. Randomized masks, modes and fault positions are mixed with directed runs that withhold resume and that drop the activate bit in the middle of a run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEL,
    S_WR,
    S_RQ,
    S_CMP,
    S_PAUSE
  } seq_st_e;

  localparam logic [3:0] RA_ACT  = 4'd0;
  localparam logic [3:0] RA_ALG  = 4'd1;
  localparam logic [3:0] RA_GLO  = 4'd2;
  localparam logic [3:0] RA_GHI  = 4'd3;
  localparam logic [3:0] RA_OVR  = 4'd4;
  localparam logic [3:0] RA_SRC  = 4'd5;
  localparam logic [3:0] RA_GO   = 4'd6;
  localparam logic [3:0] RA_CMD  = 4'd7;
  localparam logic [3:0] RA_STAT = 4'd8;
  localparam logic [3:0] RA_LOC  = 4'd9;
  localparam logic [3:0] RA_CNT  = 4'd10;
  localparam logic [3:0] RA_FADR = 4'd11;
  localparam logic [3:0] RA_FDAT = 4'd12;

  localparam logic [7:0] GO_CODE     = 8'h14;
  localparam logic [7:0] RESUME_CODE = 8'h02;
  localparam logic [1:0] SRC_ROM     = 2'd3;

endpackage

// File: rtl/mbist_sram.sv
module mbist_sram #(
  parameter int GRP_W  = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int AW    = GRP_W + ADDR_W,
  localparam int WORDS = 1 << AW,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              flt_en,
  input  logic [AW-1:0]     flt_loc,
  input  logic [BIT_W-1:0]  flt_bit
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] flip_q;

  // plain synchronous-read array so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flip_q <= '0;
    end else if (flt_en && raddr == flt_loc) begin
      flip_q <= DATA_W'(1) << flt_bit;
    end else begin
      flip_q <= '0;
    end
  end

  assign rdata = rd_q ^ flip_q;

endmodule

// File: rtl/mbist_regs.sv
module mbist_regs
  import mbist_pkg::*;
#(
  parameter int N_ALGO = 4,
  parameter int N_GRP  = 8,
  parameter int RW     = 8,
  localparam int HALF  = N_GRP / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [3:0]        waddr,
  input  logic [RW-1:0]     wdata,
  input  logic [3:0]        raddr,
  output logic [RW-1:0]     rdata,
  output logic              act,
  output logic [N_ALGO-1:0] alg_msk,
  output logic [N_GRP-1:0]  grp_msk,
  output logic              ovr,
  output logic              start,
  output logic              resume,
  input  logic [RW-1:0]     stat_b,
  input  logic [RW-1:0]     loc_b,
  input  logic [RW-1:0]     cnt_b,
  input  logic [RW-1:0]     fadr_b,
  input  logic [RW-1:0]     fdat_b
);

  logic [HALF-1:0] glo, ghi;
  logic [1:0]      src;
  logic [RW-1:0]   rmux;

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      alg_msk <= '1;
      glo     <= '0;
      ghi     <= '0;
      ovr     <= 1'b1;
      src     <= '0;
      rdata   <= '0;
    end else begin
      rdata <= rmux;
      if (wr) begin
        case (waddr)
          RA_ACT: act     <= wdata[0];
          RA_ALG: alg_msk <= wdata[N_ALGO-1:0];
          RA_GLO: glo     <= wdata[HALF-1:0];
          RA_GHI: ghi     <= wdata[HALF-1:0];
          RA_OVR: ovr     <= wdata[0];
          RA_SRC: src     <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  assign grp_msk = {ghi, glo};
  assign start   = wr && waddr == RA_GO && wdata == GO_CODE && act && src == SRC_ROM;
  assign resume  = wr && waddr == RA_CMD && wdata == RESUME_CODE;

  always_comb begin
    case (raddr)
      RA_ACT:  rmux = RW'(act);
      RA_ALG:  rmux = RW'(alg_msk);
      RA_GLO:  rmux = RW'(glo);
      RA_GHI:  rmux = RW'(ghi);
      RA_OVR:  rmux = RW'(ovr);
      RA_SRC:  rmux = RW'(src);
      RA_STAT: rmux = stat_b;
      RA_LOC:  rmux = loc_b;
      RA_CNT:  rmux = cnt_b;
      RA_FADR: rmux = fadr_b;
      RA_FDAT: rmux = fdat_b;
      default: rmux = '0;
    endcase
  end

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int N_ALGO = 4,
  parameter int N_GRP  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2,
  localparam int ALG_W = $clog2(N_ALGO),
  localparam int GRP_W = $clog2(N_GRP),
  localparam int AW    = GRP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic [N_ALGO-1:0] alg_msk,
  input  logic [N_GRP-1:0]  grp_msk,
  input  logic              ovr,
  input  logic              start,
  input  logic              resume,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [AW-1:0]     mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic              paused,
  output logic [ALG_W-1:0]  f_alg,
  output logic [GRP_W-1:0]  f_grp,
  output logic [CNT_W-1:0]  f_cnt,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_data
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  seq_st_e           state;
  logic [ALG_W-1:0]  alg, nxt_alg;
  logic [GRP_W-1:0]  grp, nxt_grp;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] exp_d;
  logic              pair_en, last_addr, last_pair, mismatch;

  function automatic logic [DATA_W-1:0] pat_f(input logic [ALG_W-1:0] a,
                                              input logic [ADDR_W-1:0] ad);
    logic [DATA_W-1:0] rep, alt;
    logic [1:0]        k;
    k = 2'(a);
    for (int i = 0; i < DATA_W; i++) begin
      rep[i] = ad[i % ADDR_W];
      alt[i] = (i % 2) == 1;
    end
    case (k)
      2'd0:    return '1;
      2'd1:    return alt;
      2'd2:    return rep;
      default: return ~rep;
    endcase
  endfunction

  always_comb begin
    pair_en   = alg_msk[alg] && grp_msk[grp] && (!ovr || (grp[0] == alg[0]));
    last_addr = (addr == '1);
    last_pair = (alg == ALG_W'(N_ALGO - 1)) && (grp == GRP_W'(N_GRP - 1));
    nxt_grp   = grp + 1'b1;
    nxt_alg   = (grp == GRP_W'(N_GRP - 1)) ? alg + 1'b1 : alg;
    exp_d     = pat_f(alg, addr);
    mismatch  = (mem_rdata != exp_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      alg    <= '0;
      grp    <= '0;
      addr   <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
      f_alg  <= '0;
      f_grp  <= '0;
      f_cnt  <= '0;
      f_addr <= '0;
      f_data <= '0;
    end else if (act) begin
      case (state)
        S_IDLE: if (start) begin
          alg    <= '0;
          grp    <= '0;
          addr   <= '0;
          done   <= 1'b0;
          fail   <= 1'b0;
          f_alg  <= '0;
          f_grp  <= '0;
          f_cnt  <= '0;
          f_addr <= '0;
          f_data <= '0;
          state  <= S_SEL;
        end
        S_SEL: begin
          if (pair_en) begin
            addr  <= '0;
            state <= S_WR;
          end else if (last_pair) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            alg <= nxt_alg;
            grp <= nxt_grp;
          end
        end
        S_WR: begin
          addr <= addr + 1'b1;
          if (last_addr) state <= S_RQ;
        end
        S_RQ: state <= S_CMP;
        S_CMP, S_PAUSE: begin
          if (state == S_CMP && mismatch) begin
            fail <= 1'b1;
            if (f_cnt != CMAX) f_cnt <= f_cnt + 1'b1;
            if (f_cnt == '0) begin
              f_alg  <= alg;
              f_grp  <= grp;
              f_addr <= addr;
              f_data <= mem_rdata;
            end
            state <= S_PAUSE;
          end else if (state == S_CMP || resume) begin
            if (!last_addr) begin
              addr  <= addr + 1'b1;
              state <= S_RQ;
            end else if (last_pair) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              alg   <= nxt_alg;
              grp   <= nxt_grp;
              state <= S_SEL;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_we    = act && state == S_WR;
  assign mem_waddr = {grp, addr};
  assign mem_wdata = exp_d;
  assign mem_raddr = {grp, addr};
  assign paused    = (state == S_PAUSE);

  AST_PAUSE_FAIL: assert property (@(posedge clk) disable iff (rst) paused |-> fail); // R5
  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (f_cnt != '0 && !start) |=> ($stable(f_addr) && $stable(f_data) && $stable(f_grp))); // R6
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (f_cnt == CMAX && !start) |=> (f_cnt == CMAX)); // R7
  AST_HOLD_PAUSE: assert property (@(posedge clk) disable iff (rst)
    (state == S_PAUSE && !resume) |=> (state == S_PAUSE)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (state == S_IDLE)); // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !act |=> ($stable(state) && $stable(addr) && $stable(grp))); // R10

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
  parameter int N_ALGO = 4,
  parameter int N_GRP  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2,
  localparam int RW    = 8,
  localparam int ALG_W = $clog2(N_ALGO),
  localparam int GRP_W = $clog2(N_GRP),
  localparam int AW    = GRP_W + ADDR_W,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  input  logic [3:0]        reg_raddr,
  output logic [RW-1:0]     reg_rdata,
  input  logic              flt_en,
  input  logic [GRP_W-1:0]  flt_grp,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic [BIT_W-1:0]  flt_bit
);

  logic              act, ovr, start, resume;
  logic [N_ALGO-1:0] alg_msk;
  logic [N_GRP-1:0]  grp_msk;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              done, fail, paused;
  logic [ALG_W-1:0]  f_alg;
  logic [GRP_W-1:0]  f_grp;
  logic [CNT_W-1:0]  f_cnt;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;

  mbist_regs #(.N_ALGO(N_ALGO), .N_GRP(N_GRP), .RW(RW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .waddr   (reg_addr),
    .wdata   (reg_wdata),
    .raddr   (reg_raddr),
    .rdata   (reg_rdata),
    .act     (act),
    .alg_msk (alg_msk),
    .grp_msk (grp_msk),
    .ovr     (ovr),
    .start   (start),
    .resume  (resume),
    .stat_b  (RW'({paused, fail, done})),
    .loc_b   (RW'({f_alg, f_grp})),
    .cnt_b   (RW'(f_cnt)),
    .fadr_b  (RW'(f_addr)),
    .fdat_b  (RW'(f_data))
  );

  mbist_seq #(
    .N_ALGO(N_ALGO), .N_GRP(N_GRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .alg_msk   (alg_msk),
    .grp_msk   (grp_msk),
    .ovr       (ovr),
    .start     (start),
    .resume    (resume),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .done      (done),
    .fail      (fail),
    .paused    (paused),
    .f_alg     (f_alg),
    .f_grp     (f_grp),
    .f_cnt     (f_cnt),
    .f_addr    (f_addr),
    .f_data    (f_data)
  );

  mbist_sram #(.GRP_W(GRP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
    .clk     (clk),
    .rst     (rst),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr   (mem_raddr),
    .rdata   (mem_rdata),
    .flt_en  (flt_en),
    .flt_loc ({flt_grp, flt_addr}),
    .flt_bit (flt_bit)
  );

endmodule

// File: tb/tb_mbist_ctrl.sv
`timescale 1ns/1ps
module tb_mbist_ctrl;

  localparam logic [3:0] A_ACT = 4'd0, A_ALG = 4'd1, A_GLO = 4'd2, A_GHI = 4'd3,
                         A_OVR = 4'd4, A_SRC = 4'd5, A_GO = 4'd6, A_CMD = 4'd7,
                         A_STAT = 4'd8, A_LOC = 4'd9, A_CNT = 4'd10, A_FADR = 4'd11,
                         A_FDAT = 4'd12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [3:0] reg_raddr = '0;
  logic [7:0] reg_rdata;
  logic       flt_en = 1'b0;
  logic [2:0] flt_grp = '0;
  logic [3:0] flt_addr = '0;
  logic [2:0] flt_bit = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mbist_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .flt_en(flt_en), .flt_grp(flt_grp),
    .flt_addr(flt_addr), .flt_bit(flt_bit)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int a, input int ad);
    logic [3:0] n;
    n = 4'(ad);
    case (a % 4)
      0: return 8'hFF;
      1: return 8'hAA;
      2: return {n, n};
      default: return ~{n, n};
    endcase
  endfunction

  function automatic bit pen(input int a, input int g, input logic [3:0] am,
                             input logic [3:0] lo, input logic [3:0] hi, input bit ov);
    logic [7:0] gm;
    gm = {hi, lo};
    return am[a] && gm[g] && (!ov || ((a % 2) == (g % 2)));
  endfunction

  // poll STAT until one of the bits in msk is set
  task automatic wait_stat(input logic [7:0] msk, output logic [7:0] st);
    st = '0;
    for (int it = 0; it < 4000; it++) begin
      rd(A_STAT, st);
      if ((st & msk) != 0) break;
    end
  endtask

  task automatic run_case(input logic [3:0] am, input logic [3:0] lo, input logic [3:0] hi,
                          input bit ov, input bit fe, input int fg, input int fa, input int fb);
    int n, fa_alg, pauses;
    logic [7:0] st, v;
    flt_en = fe; flt_grp = 3'(fg); flt_addr = 4'(fa); flt_bit = 3'(fb);
    wr(A_ACT, 8'd1); wr(A_ALG, {4'd0, am}); wr(A_GLO, {4'd0, lo}); wr(A_GHI, {4'd0, hi});
    wr(A_OVR, {7'd0, ov}); wr(A_SRC, 8'd3);
    n = 0; fa_alg = -1;
    for (int a = 0; a < 4; a++) begin
      if (fe && pen(a, fg, am, lo, hi, ov)) begin
        if (fa_alg < 0) fa_alg = a;
        n++;
      end
    end
    wr(A_GO, 8'h14);
    pauses = 0;
    st = '0;
    for (int it = 0; it < 4000; it++) begin
      rd(A_STAT, st);
      if (st[0]) break;
      if (st[2]) begin
        pauses++;
        if (pauses == 1) begin
          rd(A_LOC, v);  chk("R5 loc", int'(v), fa_alg * 8 + fg);
          rd(A_FADR, v); chk("R5 fadr", int'(v), fa);
          rd(A_FDAT, v); chk("R4 fdat", int'(v), int'(pat(fa_alg, fa) ^ (8'd1 << fb)));
        end
        wr(A_CMD, 8'h02);
      end
    end
    chk("R9 done", int'(st[0]), 1);
    chk("R9 fail flag", int'(st[1]), (n > 0) ? 1 : 0);
    chk("R8 pauses", pauses, n);
    chk("R3 pair count", pauses, n);
    rd(A_CNT, v); chk("R7 count", int'(v), (n > 3) ? 3 : n);
    if (n > 1) begin
      rd(A_FADR, v); chk("R6 fadr kept", int'(v), fa);
      rd(A_FDAT, v); chk("R6 fdat kept", int'(v), int'(pat(fa_alg, fa) ^ (8'd1 << fb)));
      rd(A_LOC, v);  chk("R6 loc kept", int'(v), fa_alg * 8 + fg);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, st;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(A_ALG, v);  chk("R1 alg reset", int'(v), 15);
    rd(A_OVR, v);  chk("R1 ovr reset", int'(v), 1);
    rd(A_ACT, v);  chk("R1 act reset", int'(v), 0);
    rd(A_SRC, v);  chk("R1 src reset", int'(v), 0);
    rd(A_STAT, v); chk("R1 stat reset", int'(v), 0);

    // R2: start guards (group masks zero, so a real start would finish quickly)
    wr(A_SRC, 8'd3); wr(A_GO, 8'h14);
    repeat (60) @(negedge clk);
    rd(A_STAT, v); chk("R2 no start without ACT", int'(v), 0);
    wr(A_ACT, 8'd1); wr(A_SRC, 8'd1); wr(A_GO, 8'h14);
    repeat (60) @(negedge clk);
    rd(A_STAT, v); chk("R2 no start with SRC!=3", int'(v), 0);
    wr(A_SRC, 8'd3); wr(A_GO, 8'h15);
    repeat (60) @(negedge clk);
    rd(A_STAT, v); chk("R2 no start with wrong code", int'(v), 0);
    wr(A_GO, 8'h14);
    wait_stat(8'h01, st); chk("R2 start with code 0x14", int'(st), 1);

    // R9: clean pass over all pairs
    run_case(4'hF, 4'hF, 4'hF, 1'b1, 1'b0, 0, 0, 0);
    // R3: type match in normal mode, only algorithms 0 and 2 touch group 2
    run_case(4'hF, 4'hF, 4'hF, 1'b1, 1'b1, 2, 5, 3);
    // R3/R7: override runs all four on group 2, count saturates at 3
    run_case(4'hF, 4'hF, 4'hF, 1'b0, 1'b1, 2, 5, 3);
    // R4: address patterns, fault in upper group
    run_case(4'b1100, 4'h0, 4'b0010, 1'b0, 1'b1, 5, 9, 6);

    // R8: a wrong CMD value does not resume
    flt_en = 1'b1; flt_grp = 3'd1; flt_addr = 4'd0; flt_bit = 3'd0;
    wr(A_ALG, 8'h02); wr(A_GLO, 8'h02); wr(A_GHI, 8'h00); wr(A_OVR, 8'd0);
    wr(A_GO, 8'h14);
    wait_stat(8'h04, st); chk("R5 paused with fail", int'(st), 6);
    wr(A_CMD, 8'h03);
    repeat (20) @(negedge clk);
    rd(A_STAT, v); chk("R8 CMD 3 ignored", int'(v), 6);
    rd(A_CNT, v);  chk("R8 count unchanged", int'(v), 1);
    wr(A_CMD, 8'h02);
    wait_stat(8'h01, st); chk("R8 resume reaches done", int'(st), 3);

    // R10: dropping ACT freezes the run
    flt_en = 1'b0;
    wr(A_ALG, 8'h0F); wr(A_GLO, 8'h0F); wr(A_GHI, 8'h0F); wr(A_OVR, 8'd1);
    wr(A_GO, 8'h14);
    repeat (30) @(negedge clk);
    wr(A_ACT, 8'd0);
    repeat (1500) @(negedge clk);
    rd(A_STAT, v); chk("R10 frozen, no done", int'(v), 0);
    wr(A_ACT, 8'd1);
    wait_stat(8'h01, st); chk("R10 resumes to done", int'(st), 1);

    // randomized runs
    for (int r = 0; r < 12; r++) begin
      run_case(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
               ($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 16), int'($urandom % 8));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule